// File: doc/BRIEF.md
# Filter Data-Ready Interrupt Selector

This block raises one data-ready interrupt for each channel of a bank of decimation filters. Every channel has two possible sources. The first is an acknowledge pulse, which the channel's filter raises when it has a new result. The second is a FIFO threshold condition, which is true while the FIFO fill count is at or above a programmed level. A per-channel mode bit picks one of the two sources, and each path has its own enable gating. The selected source is registered onto the channel's interrupt output.

Each source also keeps a sticky flag that software can read. A flag is cleared by a clear strobe, but only once its source has gone quiet. A clear that arrives while the source is still high has no effect, so a live condition is never lost. The filters, the FIFO storage and the bus decoding sit outside the block. The fill counts, the event pulses, the per-channel configuration write strobes and the clear strobes reach the block as plain input ports.

Each channel has a 4-bit configuration word. Bit 0 is the mode select (0 = acknowledge source, 1 = FIFO threshold source). Bit 1 enables the acknowledge interrupt. Bit 2 enables the FIFO interrupt. Bit 3 enables the FIFO.

Top module: `drint_sel`

## Requirements
- R1: While `rst_n` is low at a clock edge, every flag, every configuration bit and every interrupt output becomes 0, whatever the other inputs are.
- R2: An acknowledge pulse on a channel sets that channel's acknowledge flag at the next edge. The flag then holds at 1 until it is cleared.
- R3: A clear strobe for the acknowledge flag takes effect only when that channel's acknowledge input is low in the same cycle. When the event and the clear arrive together, the flag stays 1.
- R4: A channel's FIFO condition is true when its 5-bit fill count is greater than or equal to its 5-bit level, compared as unsigned numbers. A true condition sets the channel's sticky FIFO flag at the next edge. A change to the fill count or the level is seen at the next edge.
- R5: A clear strobe for the FIFO flag takes effect only while the FIFO condition of that channel is false. When the condition is true, the flag stays 1.
- R6: With mode bit 0 and acknowledge enable 0, the channel's interrupt output is 0.
- R7: With mode bit 0 and acknowledge enable 1, the interrupt output equals the acknowledge input one cycle earlier.
- R8: With mode bit 1, the interrupt output equals the FIFO condition one cycle earlier when both the FIFO interrupt enable (bit 2) and the FIFO enable (bit 3) are 1. Otherwise the output is 0.
- R9: Events, levels, clears and configuration on one channel have no effect on any other channel's flags or output.
- R10: A configuration write strobe for a channel loads `cfg_wdata` into that channel's configuration at the edge. The new setting governs the interrupt output from the following edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_evt | input | NCH | Per-channel acknowledge pulse from the filter |
| ff_fill | input | NCH*LW | Packed FIFO fill counts; channel c is at bits [c*LW +: LW] |
| ff_lvl | input | NCH*LW | Packed programmed FIFO interrupt levels |
| cfg_we | input | NCH | Per-channel configuration write strobe |
| cfg_wdata | input | 4 | Configuration word: bit0 mode, bit1 ack enable, bit2 FIFO int enable, bit3 FIFO enable |
| clr_ack | input | NCH | Per-channel clear strobe for the acknowledge flag |
| clr_ff | input | NCH | Per-channel clear strobe for the FIFO flag |
| ack_flag | output | NCH | Sticky acknowledge flags |
| fifo_flag | output | NCH | Sticky FIFO threshold flags |
| drint | output | NCH | Per-channel data-ready interrupt |

## Verification
The hardest case to reach from the ports is a clear strobe landing in the very cycle its source is still high. Random traffic seldom lines this up with a flag that is already set, or with a fill count sitting exactly on the level. The stimulus therefore starts with directed sequences. These hold the acknowledge input high during a clear, put the fill count equal to the level and one below it, and clear on the extreme count 31 against level 30. Seeded random traffic follows, with frequent clear strobes and rare configuration writes, so every mode and enable combination is visited with the flags in both states.

// File: rtl/drint_sel.sv
`timescale 1ns/1ps
module drint_sel #(
  parameter int NCH = 4,
  parameter int LW  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    ack_evt,
  input  logic [NCH*LW-1:0] ff_fill,
  input  logic [NCH*LW-1:0] ff_lvl,
  input  logic [NCH-1:0]    cfg_we,
  input  logic [3:0]        cfg_wdata,
  input  logic [NCH-1:0]    clr_ack,
  input  logic [NCH-1:0]    clr_ff,
  output logic [NCH-1:0]    ack_flag,
  output logic [NCH-1:0]    fifo_flag,
  output logic [NCH-1:0]    drint
);
  logic [NCH-1:0] sel_q, aie_q, fie_q, fen_q;
  logic [NCH-1:0] ff_rdy;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ff_rdy[c] = ff_fill[c*LW +: LW] >= ff_lvl[c*LW +: LW];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q[c]     <= 1'b0;
        aie_q[c]     <= 1'b0;
        fie_q[c]     <= 1'b0;
        fen_q[c]     <= 1'b0;
        ack_flag[c]  <= 1'b0;
        fifo_flag[c] <= 1'b0;
        drint[c]     <= 1'b0;
      end else begin
        if (cfg_we[c]) begin
          sel_q[c] <= cfg_wdata[0];
          aie_q[c] <= cfg_wdata[1];
          fie_q[c] <= cfg_wdata[2];
          fen_q[c] <= cfg_wdata[3];
        end
        if (ack_evt[c])    ack_flag[c] <= 1'b1;
        else if (clr_ack[c]) ack_flag[c] <= 1'b0;
        if (ff_rdy[c])     fifo_flag[c] <= 1'b1;
        else if (clr_ff[c])  fifo_flag[c] <= 1'b0;
        drint[c] <= sel_q[c] ? (fie_q[c] & fen_q[c] & ff_rdy[c])
                             : (aie_q[c] & ack_evt[c]);
      end
    end
  end
endmodule

// File: rtl/drint_sel_chk.sv
`timescale 1ns/1ps
module drint_sel_chk #(
  parameter int NCH = 4,
  parameter int LW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    ack_evt,
  input logic [NCH*LW-1:0] ff_fill,
  input logic [NCH*LW-1:0] ff_lvl,
  input logic [NCH-1:0]    clr_ack,
  input logic [NCH-1:0]    clr_ff,
  input logic [NCH-1:0]    cfg_sel,
  input logic [NCH-1:0]    cfg_aie,
  input logic [NCH-1:0]    cfg_fie,
  input logic [NCH-1:0]    cfg_fen,
  input logic [NCH-1:0]    ack_flag,
  input logic [NCH-1:0]    fifo_flag,
  input logic [NCH-1:0]    drint
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    // R2
    ack_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_evt[c] |=> ack_flag[c]);
    // R2
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_flag[c] && !clr_ack[c]) |=> ack_flag[c]);
    // R3
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ack[c] && !ack_evt[c]) |=> !ack_flag[c]);
    // R4
    ff_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ff_fill[c*LW +: LW] >= ff_lvl[c*LW +: LW]) |=> fifo_flag[c]);
    // R5
    ff_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_ff[c] && (ff_fill[c*LW +: LW] < ff_lvl[c*LW +: LW])) |=> !fifo_flag[c]);
    // R6
    ack_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sel[c] && !cfg_aie[c]) |=> !drint[c]);
    // R7
    ack_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_sel[c] && cfg_aie[c]) |=> (drint[c] == $past(ack_evt[c])));
    // R8
    ff_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel[c] && !(cfg_fie[c] && cfg_fen[c])) |=> !drint[c]);
  end
endmodule

bind drint_sel drint_sel_chk #(.NCH(NCH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_evt(ack_evt), .ff_fill(ff_fill),
  .ff_lvl(ff_lvl), .clr_ack(clr_ack), .clr_ff(clr_ff),
  .cfg_sel(sel_q), .cfg_aie(aie_q), .cfg_fie(fie_q), .cfg_fen(fen_q),
  .ack_flag(ack_flag), .fifo_flag(fifo_flag), .drint(drint)
);

// File: tb/tb_drint_sel.sv
`timescale 1ns/1ps
module tb_drint_sel;
  localparam int NCH = 4;
  localparam int LW  = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic [NCH-1:0]    ack_evt, cfg_we, clr_ack, clr_ff;
  logic [NCH*LW-1:0] ff_fill, ff_lvl;
  logic [3:0]        cfg_wdata;
  logic [NCH-1:0]    ack_flag, fifo_flag, drint;

  int nchk = 0;
  int nfail = 0;

  logic [NCH-1:0] m_af, m_ff, m_dr, m_sel, m_aie, m_fie, m_fen;

  always #10 clk = ~clk;

  drint_sel #(.NCH(NCH), .LW(LW)) dut (
    .clk(clk), .rst_n(rst_n), .ack_evt(ack_evt), .ff_fill(ff_fill),
    .ff_lvl(ff_lvl), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .clr_ack(clr_ack), .clr_ff(clr_ff), .ack_flag(ack_flag),
    .fifo_flag(fifo_flag), .drint(drint)
  );

  function automatic logic exp_rdy(input logic [LW-1:0] f, input logic [LW-1:0] l);
    return f >= l;
  endfunction

  function automatic logic exp_flag(input logic cur, input logic src, input logic clr);
    if (src) return 1'b1;
    if (clr) return 1'b0;
    return cur;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < NCH; c++) begin
      if (!rst_n) begin
        m_af[c] = 0; m_ff[c] = 0; m_dr[c] = 0;
        m_sel[c] = 0; m_aie[c] = 0; m_fie[c] = 0; m_fen[c] = 0;
      end else begin
        logic rdy;
        rdy = exp_rdy(ff_fill[c*LW +: LW], ff_lvl[c*LW +: LW]);
        m_dr[c] = m_sel[c] ? (m_fie[c] & m_fen[c] & rdy) : (m_aie[c] & ack_evt[c]);
        m_af[c] = exp_flag(m_af[c], ack_evt[c], clr_ack[c]);
        m_ff[c] = exp_flag(m_ff[c], rdy, clr_ff[c]);
        if (cfg_we[c]) begin
          m_sel[c] = cfg_wdata[0]; m_aie[c] = cfg_wdata[1];
          m_fie[c] = cfg_wdata[2]; m_fen[c] = cfg_wdata[3];
        end
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      string t;
      t = m_sel[c] ? "R8" : (m_aie[c] ? "R7" : "R6");
      chk(t, drint[c], m_dr[c]);
      chk("R3", ack_flag[c], m_af[c]);
      chk("R5", fifo_flag[c], m_ff[c]);
    end
  endtask

  task automatic idle();
    ack_evt = '0; cfg_we = '0; clr_ack = '0; clr_ff = '0; cfg_wdata = '0;
    ff_fill = '0;
    for (int c = 0; c < NCH; c++) ff_lvl[c*LW +: LW] = 5'd31;
  endtask

  task automatic set_ff(input int c, input int f, input int l);
    ff_fill[c*LW +: LW] = LW'(f);
    ff_lvl[c*LW +: LW]  = LW'(l);
  endtask

  initial begin
    #1_000_000;
    nfail++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    m_af = '0; m_ff = '0; m_dr = '0; m_sel = '0; m_aie = '0; m_fie = '0; m_fen = '0;
    idle();
    rst_n = 1'b0;
    ack_evt = '1; cfg_we = '1; cfg_wdata = 4'hF; ff_fill = '1; ff_lvl = '0;
    @(negedge clk);
    tick(); tick();
    // R1: reset holds everything at zero despite active inputs
    chk("R1", drint, 0); chk("R1", ack_flag, 0); chk("R1", fifo_flag, 0);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R1: configuration was zeroed: an ack pulse gives no interrupt
    ack_evt = 4'b1111;
    tick();
    chk("R1", drint, 0);
    idle(); clr_ack = '1;
    tick();

    // R10: ch0 ack enable write
    idle(); cfg_we = 4'b0001; cfg_wdata = 4'b0010;
    tick();
    idle(); ack_evt[0] = 1'b1;
    tick();
    chk("R10", drint[0], 1); chk("R7", drint[0], 1); chk("R2", ack_flag[0], 1);
    // R9: other channels untouched
    chk("R9", ack_flag[3:1], 0); chk("R9", drint[3:1], 0);
    // R3: clear with source still high is ignored
    clr_ack[0] = 1'b1;
    tick();
    chk("R3", ack_flag[0], 1);
    ack_evt[0] = 1'b0;
    tick();
    chk("R3", ack_flag[0], 0); chk("R7", drint[0], 0);
    // R6: ch1 unconfigured, flag set but no interrupt
    idle(); ack_evt[1] = 1'b1;
    tick();
    chk("R6", drint[1], 0); chk("R2", ack_flag[1], 1); chk("R9", ack_flag[0], 0);
    idle();
    tick();
    chk("R2", ack_flag[1], 1);

    // R4 / R8: ch2 FIFO path fully enabled
    idle(); cfg_we = 4'b0100; cfg_wdata = 4'b1101;
    tick();
    idle(); set_ff(2, 7, 7);
    tick();
    chk("R4", drint[2], 1); chk("R4", fifo_flag[2], 1);
    set_ff(2, 6, 7); clr_ff[2] = 1'b1;
    tick();
    chk("R4", drint[2], 0); chk("R5", fifo_flag[2], 0);
    clr_ff = '0; set_ff(2, 31, 30);
    tick();
    chk("R4", drint[2], 1);
    clr_ff[2] = 1'b1;
    tick();
    chk("R5", fifo_flag[2], 1);
    clr_ff = '0; cfg_we = 4'b0100; cfg_wdata = 4'b0101;
    tick();
    cfg_we = '0;
    tick();
    chk("R8", drint[2], 0);
    chk("R9", fifo_flag[1:0], 0);

    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < NCH; c++) begin
        ack_evt[c] = ($urandom % 4) == 0;
        clr_ack[c] = ($urandom % 3) == 0;
        clr_ff[c]  = ($urandom % 3) == 0;
        cfg_we[c]  = ($urandom % 16) == 0;
        ff_fill[c*LW +: LW] = LW'($urandom);
        ff_lvl[c*LW +: LW]  = LW'($urandom);
      end
      cfg_wdata = 4'($urandom);
      rst_n = ($urandom % 500) != 0;
      tick();
    end

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule